// File: doc/BRIEF.md
# Pseudo-Static RAM Access Sequencer

This block sits between a host and an asynchronous pseudo-static RAM of 256K sixteen-bit words with a flat, non-multiplexed address. The host raises a request carrying an address, write data, a read/write flag and two byte enables, and holds it until a one-clock acknowledge comes back; for reads the captured word is presented with that acknowledge. On the memory side the sequencer produces the chip enable, chip select, output enable, a lower and an upper byte write strobe, the 18-bit address and a split tri-state data bus (output value, output enable, input value).

Every cycle is timed from the falling edge of chip enable, which latches the upper address bits as the row. Chip-enable low time, precharge time, minimum cycle length, output-enable access time and strobe pulse width are given in picoseconds and turned into clock counts by rounding up against the clock period, never below one cycle. Refresh is planned by a separate block: it raises a refresh request, and the sequencer answers with a grant once it is idle, keeping the memory quiet until the request drops.

Top module: `psram_seq`

## Requirements
- R1: While reset is high, chip enable, output enable and both byte strobes are high (inactive), chip select is low, the bus output enable, acknowledge and refresh grant are low; after reset the idle flag is high.
- R2: The memory address equals the host address of the accepted request (bits 17:7 the row, bits 6:0 the column) and does not change while chip enable is low.
- R3: Chip enable stays low for at least the rounded-up chip-enable low time (120 ns at the defaults).
- R4: Between two cycles chip enable stays high for at least the precharge time (60 ns), and successive chip-enable falls are at least the cycle time (190 ns) apart; a held request is not accepted before then.
- R5: A read drives output enable low only inside the chip-enable low window and samples the bus on the clock edge where chip enable returns high, no earlier than both access times; that word appears on the read data port with the acknowledge.
- R6: The data bus is driven only in a write, only while chip enable is low and output enable is high, starting with the strobes and ending when chip enable rises.
- R7: Byte enable bit 0 selects the lower strobe (bits 7:0), bit 1 the upper strobe (bits 15:8); with both set the two strobes fall and rise on the same clock edge.
- R8: The write strobes return high at least one clock before chip enable rises, so the strobe edge latches the data while the bus is still driven.
- R9: Each accepted request yields exactly one acknowledge, one clock wide, on the edge where chip enable rises.
- R10: A refresh request seen while idle is granted on the next edge; while granted, chip enable stays high, chip select low and no host request is accepted. If a host request and a refresh request are both present in the same idle cycle, refresh is served first.
- R11: Chip select is high whenever chip enable is low, and is held through the precharge that follows.
- R12: A write with both byte enables clear still runs a full cycle and acknowledges, but asserts no strobe, drives no bus and leaves memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request, held until ack |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 low byte, bit 1 high byte |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Read data, valid with ack |
| rf_req | input | 1 | Refresh block asks for the memory |
| rf_gnt | output | 1 | Memory handed to refresh block |
| seq_idle | output | 1 | No access in progress |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_cs | output | 1 | Chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_lo_n | output | 1 | Lower byte write strobe, active low |
| mem_we_hi_n | output | 1 | Upper byte write strobe, active low |
| mem_addr | output | 18 | Memory address |
| mem_dq_o | output | 16 | Bus value when driven |
| mem_dq_oe | output | 1 | Bus driver enable |
| mem_dq_i | input | 16 | Bus value from memory |

## Verification
The two functions that can meet in one clock are the host request and the refresh request, both arriving while the sequencer is idle. The bench raises both on the same edge and checks that the grant comes on the next edge with chip enable still high, that chip enable stays high and no acknowledge appears for as long as refresh is held, and that the waiting read then runs and returns the right word once refresh drops. The memory model returns a poison value until both the chip-enable and output-enable access times have elapsed, so early sampling shows up as wrong read data.

// File: rtl/psram_seq_pkg.sv
package psram_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACT  = 2'd1,
    PH_PRE  = 2'd2,
    PH_RGNT = 2'd3
  } ph_e;

  // Interval in picoseconds to a clock count, rounded up, at least one.
  function automatic int ps_to_cyc(input int ps, input int clk_ps);
    int n;
    n = (ps + clk_ps - 1) / clk_ps;
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psram_seq_tmr.sv
module psram_seq_tmr #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  output logic [CW-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/psram_seq_dp.sv
module psram_seq_dp #(
  parameter int AW = 18,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          cap,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  input  logic [DW-1:0] mem_dq_i,
  output logic          wr_q,
  output logic [1:0]    be_q,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_o,
  output logic [DW-1:0] rdata
);

  localparam int HW = DW / 2;

  // request fields are frozen at acceptance for the whole cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q     <= 1'b0;
      be_q     <= 2'b00;
      mem_addr <= '0;
      mem_dq_o <= '0;
    end else if (take) begin
      wr_q     <= req_wr;
      be_q     <= req_be;
      mem_addr <= req_addr;
      mem_dq_o <= req_wdata;
    end
  end

  // read capture, one register per byte lane
  for (genvar g = 0; g < 2; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        rdata[g*HW +: HW] <= '0;
      end else if (cap) begin
        rdata[g*HW +: HW] <= mem_dq_i[g*HW +: HW];
      end
    end
  end

endmodule

// File: rtl/psram_seq_fsm.sv
module psram_seq_fsm
  import psram_seq_pkg::*;
#(
  parameter int LOW_CYC = 24,
  parameter int PRE_CYC = 13,
  parameter int CE_MIN  = 24,
  parameter int CW      = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          rf_req,
  input  logic          wr_q,
  input  logic [1:0]    be_q,
  input  logic [CW-1:0] cnt,
  output logic          take,
  output logic          cap,
  output logic          tmr_clr,
  output logic          tmr_en,
  output logic          idle,
  output logic          ack,
  output logic          rf_gnt,
  output logic          ce_n,
  output logic          cs,
  output logic          oe_n,
  output logic          we_lo_n,
  output logic          we_hi_n,
  output logic          dq_oe
);

  localparam logic [CW-1:0] C_LAST = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] C_SEND = CW'(LOW_CYC - 2);
  localparam logic [CW-1:0] C_PEND = CW'(PRE_CYC - 1);
  localparam int RW = CW + 2;

  ph_e  st;
  logic last_lo;
  logic pre_done;

  assign idle     = (st == PH_IDLE);
  assign take     = idle && !rf_req && req;
  assign last_lo  = (st == PH_ACT) && (cnt == C_LAST);
  assign pre_done = (st == PH_PRE) && (cnt == C_PEND);
  assign cap      = last_lo && !wr_q;
  assign tmr_clr  = take || last_lo;
  assign tmr_en   = (st == PH_ACT) || (st == PH_PRE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= PH_IDLE;
      ce_n    <= 1'b1;
      cs      <= 1'b0;
      oe_n    <= 1'b1;
      we_lo_n <= 1'b1;
      we_hi_n <= 1'b1;
      dq_oe   <= 1'b0;
      ack     <= 1'b0;
      rf_gnt  <= 1'b0;
    end else begin
      ack <= 1'b0;
      case (st)
        PH_IDLE: begin
          if (rf_req) begin
            st     <= PH_RGNT;
            rf_gnt <= 1'b1;
          end else if (req) begin
            st   <= PH_ACT;
            ce_n <= 1'b0;
            cs   <= 1'b1;
          end
        end
        PH_ACT: begin
          if (cnt == '0) begin
            oe_n    <= wr_q;
            we_lo_n <= ~(wr_q & be_q[0]);
            we_hi_n <= ~(wr_q & be_q[1]);
            dq_oe   <= wr_q & (|be_q);
          end
          if (cnt == C_SEND) begin
            we_lo_n <= 1'b1;
            we_hi_n <= 1'b1;
          end
          if (last_lo) begin
            ce_n  <= 1'b1;
            oe_n  <= 1'b1;
            dq_oe <= 1'b0;
            ack   <= 1'b1;
            st    <= PH_PRE;
          end
        end
        PH_PRE: begin
          if (pre_done) begin
            st <= PH_IDLE;
            cs <= 1'b0;
          end
        end
        default: begin
          if (!rf_req) begin
            st     <= PH_IDLE;
            rf_gnt <= 1'b0;
          end
        end
      endcase
    end
  end

  // run-length counters that let the assertions judge interval lengths
  logic [RW-1:0] lo_run;
  logic [RW-1:0] hi_run;
  logic          had_cyc;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_run  <= '0;
      hi_run  <= '0;
      had_cyc <= 1'b0;
    end else begin
      lo_run  <= ce_n ? '0 : ((&lo_run) ? lo_run : lo_run + 1'b1);
      hi_run  <= !ce_n ? '0 : ((&hi_run) ? hi_run : hi_run + 1'b1);
      if (ack) had_cyc <= 1'b1;
    end
  end

  AST_CE_LOW_MIN: assert property (@(posedge clk) disable iff (rst)
    $rose(ce_n) |-> (lo_run >= RW'(CE_MIN)));  // R3
  AST_PRECHARGE: assert property (@(posedge clk) disable iff (rst)
    ($fell(ce_n) && had_cyc) |-> (hi_run >= RW'(PRE_CYC)));  // R4
  AST_BUS_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (oe_n && !ce_n));  // R6
  AST_STROBE_PAIR: assert property (@(posedge clk) disable iff (rst)
    (!$past(we_lo_n) && !$past(we_hi_n)) |-> (we_lo_n == we_hi_n));  // R7
  AST_STROBE_IN_CE: assert property (@(posedge clk) disable iff (rst)
    ($rose(we_lo_n) || $rose(we_hi_n)) |-> !ce_n);  // R8
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);  // R9
  AST_GNT_QUIET: assert property (@(posedge clk) disable iff (rst)
    rf_gnt |-> (ce_n && !cs));  // R10
  AST_CS_COVERS: assert property (@(posedge clk) disable iff (rst)
    !ce_n |-> cs);  // R11

endmodule

// File: rtl/psram_seq.sv
module psram_seq
  import psram_seq_pkg::*;
#(
  parameter int AW       = 18,
  parameter int DW       = 16,
  parameter int CLK_PS   = 5000,
  parameter int T_CE_PS  = 120000,
  parameter int T_PRE_PS = 60000,
  parameter int T_CYC_PS = 190000,
  parameter int T_OE_PS  = 60000,
  parameter int T_WP_PS  = 35000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  output logic          ack,
  output logic [DW-1:0] rdata,
  input  logic          rf_req,
  output logic          rf_gnt,
  output logic          seq_idle,
  output logic          mem_ce_n,
  output logic          mem_cs,
  output logic          mem_oe_n,
  output logic          mem_we_lo_n,
  output logic          mem_we_hi_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);

  localparam int N_CE  = ps_to_cyc(T_CE_PS, CLK_PS);
  localparam int N_PRE = ps_to_cyc(T_PRE_PS, CLK_PS);
  localparam int N_CYC = ps_to_cyc(T_CYC_PS, CLK_PS);
  localparam int N_OE  = ps_to_cyc(T_OE_PS, CLK_PS);
  localparam int N_WP  = ps_to_cyc(T_WP_PS, CLK_PS);
  // chip enable low: access time, output-enable access after a one-clock
  // turn-off gap, and the strobe pulse framed by one clock on each side
  localparam int LOW_CYC = imax(imax(N_CE, N_OE + 1), N_WP + 2);
  // precharge state length; one idle clock always follows it
  localparam int PRE_CYC = imax(1, imax(N_PRE - 1, N_CYC - LOW_CYC - 1));
  localparam int CW      = $clog2(imax(LOW_CYC, PRE_CYC) + 1);

  logic          take;
  logic          cap;
  logic          tmr_clr;
  logic          tmr_en;
  logic          wr_q;
  logic [1:0]    be_q;
  logic [CW-1:0] cnt;

  psram_seq_tmr #(.CW(CW)) u_tmr (
    .clk (clk),
    .rst (rst),
    .clr (tmr_clr),
    .en  (tmr_en),
    .cnt (cnt)
  );

  psram_seq_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .take      (take),
    .cap       (cap),
    .req_wr    (req_wr),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .mem_dq_i  (mem_dq_i),
    .wr_q      (wr_q),
    .be_q      (be_q),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .rdata     (rdata)
  );

  psram_seq_fsm #(
    .LOW_CYC (LOW_CYC),
    .PRE_CYC (PRE_CYC),
    .CE_MIN  (N_CE),
    .CW      (CW)
  ) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .rf_req  (rf_req),
    .wr_q    (wr_q),
    .be_q    (be_q),
    .cnt     (cnt),
    .take    (take),
    .cap     (cap),
    .tmr_clr (tmr_clr),
    .tmr_en  (tmr_en),
    .idle    (seq_idle),
    .ack     (ack),
    .rf_gnt  (rf_gnt),
    .ce_n    (mem_ce_n),
    .cs      (mem_cs),
    .oe_n    (mem_oe_n),
    .we_lo_n (mem_we_lo_n),
    .we_hi_n (mem_we_hi_n),
    .dq_oe   (mem_dq_oe)
  );

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));  // R2

endmodule

// File: tb/psram_seq_tb.sv
`timescale 1ns/1ps
module psram_seq_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        req_wr = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = 2'b00;
  logic        ack;
  logic [15:0] rdata;
  logic        rf_req = 1'b0;
  logic        rf_gnt;
  logic        seq_idle;
  logic        mem_ce_n, mem_cs, mem_oe_n, mem_we_lo_n, mem_we_hi_n;
  logic [17:0] mem_addr;
  logic [15:0] mem_dq_o;
  logic        mem_dq_oe;
  logic [15:0] mem_dq_i = '0;

  always #2.5 clk = ~clk;

  psram_seq u_dut (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .ack(ack), .rdata(rdata),
    .rf_req(rf_req), .rf_gnt(rf_gnt), .seq_idle(seq_idle),
    .mem_ce_n(mem_ce_n), .mem_cs(mem_cs), .mem_oe_n(mem_oe_n),
    .mem_we_lo_n(mem_we_lo_n), .mem_we_hi_n(mem_we_hi_n),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [15:0] mdl_mem [logic [17:0]];
  logic [15:0] ref_mem [logic [17:0]];
  realtime t_ce = 0.0, t_oe = 0.0, t_rise = 0.0;
  realtime t_lo = 0.0, t_hi = 0.0;
  bit seen_fall = 1'b0, seen_rise = 1'b0, lo_fell = 1'b0, hi_fell = 1'b0;

  always @(negedge mem_oe_n) t_oe = $realtime;

  always @(negedge mem_ce_n) if (!rst) begin
    if (seen_rise)
      chk(($realtime - t_rise) >= 59.99, "R4 precharge ns",
          $rtoi($realtime - t_rise), 60);
    if (seen_fall)
      chk(($realtime - t_ce) >= 189.99, "R4 cycle ns",
          $rtoi($realtime - t_ce), 190);
    t_ce = $realtime;
    seen_fall = 1'b1;
    lo_fell = 1'b0;
    hi_fell = 1'b0;
  end

  always @(posedge mem_ce_n) if (!rst && seen_fall) begin
    chk(($realtime - t_ce) >= 119.99, "R3 ce low ns", $rtoi($realtime - t_ce), 120);
    if (lo_fell && hi_fell)
      chk(t_lo == t_hi, "R7 strobe skew ps", $rtoi((t_lo - t_hi) * 1000.0), 0);
    t_rise = $realtime;
    seen_rise = 1'b1;
  end

  always @(negedge mem_we_lo_n) begin t_lo = $realtime; lo_fell = 1'b1; end
  always @(negedge mem_we_hi_n) begin t_hi = $realtime; hi_fell = 1'b1; end

  always @(posedge mem_we_lo_n) if (!rst && mem_ce_n === 1'b0 && mem_dq_oe) begin : wl
    logic [15:0] v;
    v = mdl_mem.exists(mem_addr) ? mdl_mem[mem_addr] : 16'h0000;
    v[7:0] = mem_dq_o[7:0];
    mdl_mem[mem_addr] = v;
  end

  always @(posedge mem_we_hi_n) if (!rst && mem_ce_n === 1'b0 && mem_dq_oe) begin : wh
    logic [15:0] v;
    v = mdl_mem.exists(mem_addr) ? mdl_mem[mem_addr] : 16'h0000;
    v[15:8] = mem_dq_o[15:8];
    mdl_mem[mem_addr] = v;
  end

  // bus shows a poison value until both access times have elapsed
  initial begin
    #0.25;
    forever begin
      #0.5;
      if (mem_ce_n === 1'b0 && mem_oe_n === 1'b0 &&
          ($realtime - t_ce) >= 119.5 && ($realtime - t_oe) >= 59.5)
        mem_dq_i = mdl_mem.exists(mem_addr) ? mdl_mem[mem_addr] : 16'h0000;
      else
        mem_dq_i = 16'hDEAD;
    end
  end

  // ---------------- scoreboard ----------------
  bit          exp_wr [$];
  logic [15:0] exp_dat [$];
  bit          ack_prev = 1'b0;

  always @(negedge clk) if (!rst) begin
    if (ack_prev) chk(ack == 1'b0, "R9 ack width", ack, 0);
    if (ack) begin
      if (exp_wr.size() == 0) begin
        chk(1'b0, "R9 unexpected ack", 1, 0);
      end else begin : pop
        bit          w;
        logic [15:0] d;
        w = exp_wr.pop_front();
        d = exp_dat.pop_front();
        if (!w) chk(rdata == d, "R5 read data", rdata, d);
        else    chk(mem_ce_n == 1'b1, "R9 write ack at ce rise", mem_ce_n, 1);
      end
    end
    if (mem_dq_oe)
      chk(mem_oe_n === 1'b1 && mem_ce_n === 1'b0, "R6 bus drive window",
          {mem_oe_n, mem_ce_n}, 2'b10);
    if (mem_ce_n === 1'b0) chk(mem_cs === 1'b1, "R11 cs with ce", mem_cs, 1);
    ack_prev = ack;
  end

  task automatic do_op(input bit wr, input logic [17:0] a, input logic [15:0] d,
                       input logic [1:0] be);
    logic [15:0] v;
    v = ref_mem.exists(a) ? ref_mem[a] : 16'h0000;
    if (wr) begin
      if (be[0]) v[7:0]  = d[7:0];
      if (be[1]) v[15:8] = d[15:8];
      ref_mem[a] = v;
    end
    exp_wr.push_back(wr);
    exp_dat.push_back(v);
    @(negedge clk);
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d; req_be = be;
    do @(negedge clk); while (!ack);
    req = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(mem_ce_n == 1'b1 && mem_oe_n == 1'b1, "R1 ce/oe in reset", {mem_ce_n, mem_oe_n}, 2'b11);
    chk(mem_we_lo_n == 1'b1 && mem_we_hi_n == 1'b1, "R1 strobes in reset",
        {mem_we_lo_n, mem_we_hi_n}, 2'b11);
    chk(!mem_dq_oe && !ack && !mem_cs && !rf_gnt, "R1 drive/ack/cs/gnt in reset",
        {mem_dq_oe, ack, mem_cs, rf_gnt}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(seq_idle == 1'b1, "R1 idle after reset", seq_idle, 1);

    // R7 word, lower-only, upper-only
    do_op(1'b1, 18'h00000, 16'hA5C3, 2'b11);
    do_op(1'b0, 18'h00000, 16'h0000, 2'b11);
    do_op(1'b1, 18'h3FFFF, 16'h1234, 2'b11);
    do_op(1'b1, 18'h3FFFF, 16'hFF77, 2'b01);
    do_op(1'b0, 18'h3FFFF, 16'h0000, 2'b00);
    do_op(1'b1, 18'h3FFFF, 16'h9900, 2'b10);
    do_op(1'b0, 18'h3FFFF, 16'h0000, 2'b00);
    // R12 write with no byte enable leaves memory unchanged
    do_op(1'b1, 18'h00000, 16'h0000, 2'b00);
    do_op(1'b0, 18'h00000, 16'h0000, 2'b00);
    // R2 row-only and column-only address bits
    do_op(1'b1, 18'h00080, 16'h0BAD, 2'b11);
    do_op(1'b1, 18'h00001, 16'h7001, 2'b11);
    do_op(1'b1, 18'h20000, 16'h5EED, 2'b11);
    do_op(1'b0, 18'h00080, 16'h0000, 2'b11);
    do_op(1'b0, 18'h00001, 16'h0000, 2'b11);
    do_op(1'b0, 18'h20000, 16'h0000, 2'b11);
    do_op(1'b0, 18'h00000, 16'h0000, 2'b11);
    // R5 spread pattern, back-to-back so R4 sees held requests
    for (int i = 1; i < 9; i++)
      do_op(1'b1, 18'(i * 18'h04321), 16'(i * 16'h1357 ^ 16'hC0DE), 2'b11);
    for (int i = 1; i < 9; i++)
      do_op(1'b0, 18'(i * 18'h04321), 16'h0000, 2'b11);

    // R10 host request and refresh request in the same idle cycle
    while (!seq_idle) @(negedge clk);
    exp_wr.push_back(1'b0);
    exp_dat.push_back(ref_mem[18'h3FFFF]);
    rf_req = 1'b1;
    req = 1'b1; req_wr = 1'b0; req_addr = 18'h3FFFF; req_be = 2'b11;
    @(negedge clk);
    chk(rf_gnt == 1'b1, "R10 grant next edge", rf_gnt, 1);
    chk(mem_ce_n == 1'b1, "R10 refresh wins", mem_ce_n, 1);
    repeat (20) @(negedge clk);
    chk(mem_ce_n == 1'b1 && !mem_cs, "R10 quiet while granted", {mem_ce_n, mem_cs}, 2'b10);
    chk(ack == 1'b0 && rf_gnt == 1'b1, "R10 no access while granted", {ack, rf_gnt}, 2'b01);
    rf_req = 1'b0;
    do @(negedge clk); while (!ack);
    req = 1'b0;
    chk(rf_gnt == 1'b0, "R10 grant dropped", rf_gnt, 0);

    repeat (40) @(negedge clk);
    chk(exp_wr.size() == 0, "R9 every request acknowledged", exp_wr.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R9 watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule